// File: doc/BRIEF.md
# Adaptive Replacement Way Selector

This block picks the way to evict when a set-associative cache misses. It keeps two replacement schemes side by side for every set: a use-bit scheme (one bit per way, set on every touch, with the lowest way whose bit is clear as the victim) and a rotating-pointer scheme (a per-set pointer that walks the ways in order). Which scheme a given access follows is decided at run time.

A small fraction of sets is pinned to each scheme. These are the sample sets, chosen by the low bits of the set index. Every miss in a use-bit sample set raises a shared signed counter, and every miss in a pointer sample set lowers it. The counter saturates at both ends. All other sets follow the scheme that is currently missing less: the pointer scheme while the counter is positive, and the use-bit scheme otherwise. A way that the tag array reports as invalid is always filled before either scheme is consulted.

The victim output is combinational, so it is valid in the same cycle as the access. Per-set state and the counter update on the next rising clock edge. Tag and data storage are outside this block. The tag array supplies the per-way valid vector of the accessed set.

Top module: `repl_duel_top`

## Requirements
- R1: After reset the duel counter is zero, so `follow_b` is 0. All use bits are clear and every set's rotation pointer is way 0.
- R2: A set whose index has its low LEAD_BITS bits equal to 0 always uses the use-bit scheme (`policy_b`=0). A set whose low bits equal 1 always uses the rotation scheme (`policy_b`=1). Every other set follows `follow_b`.
- R3: A miss in a use-bit sample set adds one to the counter. A miss in a rotation sample set subtracts one. Hits and follower misses leave the counter unchanged.
- R4: The counter is a signed CTR_W-bit value that stops at +2^(CTR_W-1)-1 and at -2^(CTR_W-1), and never wraps.
- R5: `follow_b` is 1 exactly when the counter is strictly greater than zero. A counter of zero selects the use-bit scheme for followers.
- R6: On a miss where some bit of `way_valid` is 0, the victim is the lowest-numbered way with its valid bit at 0, whatever the scheme.
- R7: On a miss with all ways valid under the use-bit scheme, the victim is the lowest-numbered way whose use bit is clear.
- R8: A hit touches `acc_way` and a miss touches the victim. Touching a way sets its use bit. If that would leave every use bit of the set at 1, the other bits are cleared and only the touched bit stays set.
- R9: On a miss with all ways valid under the rotation scheme, the victim is the set's pointer. Every miss in a set moves its pointer to victim+1 modulo WAYS. Hits never move it.
- R10: `victim_vld` is 1 exactly when `acc_valid` is 1 and `acc_hit` is 0. With `acc_valid` at 0, no counter, use bit or pointer changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | A lookup completes this cycle |
| acc_set | input | $clog2(SETS) | Set index of the lookup |
| acc_hit | input | 1 | 1 for a hit, 0 for a miss |
| acc_way | input | $clog2(WAYS) | Way that hit (used only on a hit) |
| way_valid | input | WAYS | Valid bit of each way of the accessed set |
| victim_way | output | $clog2(WAYS) | Way to fill on a miss |
| victim_vld | output | 1 | `victim_way` is meaningful |
| policy_b | output | 1 | Scheme applied to this access: 1 rotation, 0 use-bit |
| follow_b | output | 1 | Scheme currently given to follower sets |

## Verification
The hardest states to reach are the two counter rails. Reaching either one takes hundreds of consecutive misses in one sample group, and the only visible effect is the exact access at which `follow_b` flips back after the counter starts moving the other way. The stimulus drives more misses than the counter range into sample sets of one kind. It then walks the counter back with a counted run of opposite misses, so the flip of the follower scheme lands on a predictable access only if saturation stopped at the rail. A second hard case is the use-bit collapse in R8. A directed fill-then-hit sequence on one set forces that collapse, and a long random mix then repeats it many times.

// File: rtl/repl_duel_pkg.sv
package repl_duel_pkg;
  // classification of a set for the duel
  typedef enum logic [1:0] {
    SK_FOLLOW   = 2'd0,
    SK_LEAD_USE = 2'd1,
    SK_LEAD_ROT = 2'd2
  } set_kind_e;
endpackage

// File: rtl/repl_set_class.sv
module repl_set_class
  import repl_duel_pkg::*;
#(
  parameter int SET_W     = 6,
  parameter int LEAD_BITS = 5
) (
  input  logic [SET_W-1:0] set_idx,
  output set_kind_e        kind
);
  localparam int LB = (LEAD_BITS > SET_W) ? SET_W : LEAD_BITS;

  function automatic set_kind_e classify(input logic [LB-1:0] low);
    if (low == LB'(0))      return SK_LEAD_USE;
    else if (low == LB'(1)) return SK_LEAD_ROT;
    else                    return SK_FOLLOW;
  endfunction

  assign kind = classify(set_idx[LB-1:0]);
endmodule

// File: rtl/repl_duel_ctr.sv
module repl_duel_ctr #(
  parameter int CTR_W = 10
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    inc,
  input  logic                    dec,
  output logic signed [CTR_W-1:0] ctr_q,
  output logic                    prefer_b
);
  localparam logic signed [CTR_W-1:0] CMAX = {1'b0, {(CTR_W-1){1'b1}}};
  localparam logic signed [CTR_W-1:0] CMIN = {1'b1, {(CTR_W-1){1'b0}}};
  localparam logic signed [CTR_W-1:0] ONE  = CTR_W'(1);

  function automatic logic signed [CTR_W-1:0] sat_step(
    input logic signed [CTR_W-1:0] cur, input logic up, input logic dn);
    logic signed [CTR_W-1:0] nxt;
    nxt = cur;
    if (up && !dn && cur != CMAX) nxt = cur + ONE;
    if (dn && !up && cur != CMIN) nxt = cur - ONE;
    return nxt;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) ctr_q <= '0;
    else        ctr_q <= sat_step(ctr_q, inc, dec);
  end

  assign prefer_b = !ctr_q[CTR_W-1] && (ctr_q != '0);
endmodule

// File: rtl/repl_way_state.sv
module repl_way_state #(
  parameter int SETS = 64,
  parameter int WAYS = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     acc_valid,
  input  logic [$clog2(SETS)-1:0]  acc_set,
  input  logic                     acc_hit,
  input  logic [$clog2(WAYS)-1:0]  acc_way,
  input  logic [WAYS-1:0]          way_valid,
  input  logic                     use_rot,
  output logic [$clog2(WAYS)-1:0]  victim_way,
  output logic                     victim_vld,
  output logic [WAYS-1:0]          cur_use,
  output logic [$clog2(WAYS)-1:0]  cur_ptr
);
  localparam int WAY_W = $clog2(WAYS);

  logic [WAYS-1:0]  use_q [SETS];
  logic [WAY_W-1:0] ptr_q [SETS];
  logic [WAY_W-1:0] touch_way;
  logic             has_free;

  function automatic logic [WAY_W-1:0] lowest_zero(input logic [WAYS-1:0] v);
    logic [WAY_W-1:0] idx;
    idx = '0;
    for (int i = WAYS - 1; i >= 0; i--)
      if (!v[i]) idx = WAY_W'(i);
    return idx;
  endfunction

  function automatic logic [WAYS-1:0] touch(input logic [WAYS-1:0] bits,
                                            input logic [WAY_W-1:0] w);
    logic [WAYS-1:0] oh;
    oh    = '0;
    oh[w] = 1'b1;
    if ((bits | oh) == {WAYS{1'b1}}) return oh;
    return bits | oh;
  endfunction

  function automatic logic [WAY_W-1:0] next_way(input logic [WAY_W-1:0] w);
    if (w == WAY_W'(WAYS - 1)) return '0;
    return w + WAY_W'(1);
  endfunction

  always_comb begin
    cur_use    = use_q[acc_set];
    cur_ptr    = ptr_q[acc_set];
    has_free   = ~&way_valid;
    victim_vld = acc_valid && !acc_hit;
    if (has_free)     victim_way = lowest_zero(way_valid);
    else if (use_rot) victim_way = cur_ptr;
    else              victim_way = lowest_zero(cur_use);
    touch_way = acc_hit ? acc_way : victim_way;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) begin
        use_q[s] <= '0;
        ptr_q[s] <= '0;
      end
    end else if (acc_valid) begin
      use_q[acc_set] <= touch(cur_use, touch_way);
      if (!acc_hit) ptr_q[acc_set] <= next_way(victim_way);
    end
  end
endmodule

// File: rtl/repl_duel_top.sv
module repl_duel_top
  import repl_duel_pkg::*;
#(
  parameter int SETS      = 64,
  parameter int WAYS      = 4,
  parameter int LEAD_BITS = 5,
  parameter int CTR_W     = 10
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    acc_valid,
  input  logic [$clog2(SETS)-1:0] acc_set,
  input  logic                    acc_hit,
  input  logic [$clog2(WAYS)-1:0] acc_way,
  input  logic [WAYS-1:0]         way_valid,
  output logic [$clog2(WAYS)-1:0] victim_way,
  output logic                    victim_vld,
  output logic                    policy_b,
  output logic                    follow_b
);
  localparam int SET_W = $clog2(SETS);
  localparam int WAY_W = $clog2(WAYS);

  set_kind_e               kind;
  logic                    lead_a;
  logic                    lead_b;
  logic                    miss_evt;
  logic signed [CTR_W-1:0] ctr_q;
  logic [WAYS-1:0]         cur_use;
  logic [WAY_W-1:0]        cur_ptr;

  repl_set_class #(.SET_W(SET_W), .LEAD_BITS(LEAD_BITS)) u_class (
    .set_idx (acc_set),
    .kind    (kind)
  );

  assign lead_a   = (kind == SK_LEAD_USE);
  assign lead_b   = (kind == SK_LEAD_ROT);
  assign miss_evt = acc_valid && !acc_hit;
  assign policy_b = lead_b || (!lead_a && follow_b);

  repl_duel_ctr #(.CTR_W(CTR_W)) u_ctr (
    .clk      (clk),
    .rst_n    (rst_n),
    .inc      (miss_evt && lead_a),
    .dec      (miss_evt && lead_b),
    .ctr_q    (ctr_q),
    .prefer_b (follow_b)
  );

  repl_way_state #(.SETS(SETS), .WAYS(WAYS)) u_ways (
    .clk        (clk),
    .rst_n      (rst_n),
    .acc_valid  (acc_valid),
    .acc_set    (acc_set),
    .acc_hit    (acc_hit),
    .acc_way    (acc_way),
    .way_valid  (way_valid),
    .use_rot    (policy_b),
    .victim_way (victim_way),
    .victim_vld (victim_vld),
    .cur_use    (cur_use),
    .cur_ptr    (cur_ptr)
  );
endmodule

// File: rtl/repl_duel_chk.sv
module repl_duel_chk #(
  parameter int WAYS  = 4,
  parameter int WAY_W = 2,
  parameter int CTR_W = 10
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic [WAYS-1:0]         way_valid,
  input logic [WAY_W-1:0]        victim_way,
  input logic                    victim_vld,
  input logic                    policy_b,
  input logic                    lead_a,
  input logic                    lead_b,
  input logic                    miss_evt,
  input logic signed [CTR_W-1:0] ctr_q,
  input logic [WAYS-1:0]         cur_use,
  input logic [WAY_W-1:0]        cur_ptr
);
  localparam logic signed [CTR_W-1:0] CMAX = {1'b0, {(CTR_W-1){1'b1}}};
  localparam logic signed [CTR_W-1:0] CMIN = {1'b1, {(CTR_W-1){1'b0}}};
  localparam logic signed [CTR_W-1:0] ONE  = CTR_W'(1);

  p_lead_use_r2: assert property (@(posedge clk) disable iff (!rst_n)
    lead_a |-> !policy_b);
  p_lead_rot_r2: assert property (@(posedge clk) disable iff (!rst_n)
    lead_b |-> policy_b);
  p_ctr_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(miss_evt && (lead_a || lead_b)) |=> $stable(ctr_q));
  p_ctr_up_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (miss_evt && lead_a && ctr_q != CMAX) |=> (ctr_q == $past(ctr_q) + ONE));
  p_ctr_down_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (miss_evt && lead_b && ctr_q != CMIN) |=> (ctr_q == $past(ctr_q) - ONE));
  p_no_wrap_hi_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ctr_q == CMAX) |=> (ctr_q != CMIN));
  p_no_wrap_lo_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ctr_q == CMIN) |=> (ctr_q != CMAX));
  p_free_first_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (victim_vld && !(&way_valid)) |-> !way_valid[victim_way]);
  p_use_victim_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (victim_vld && !policy_b && (&way_valid)) |-> !cur_use[victim_way]);
  p_use_never_full_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cur_use != {WAYS{1'b1}});
  p_rot_victim_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (victim_vld && policy_b && (&way_valid)) |-> (victim_way == cur_ptr));
endmodule

bind repl_duel_top repl_duel_chk #(
  .WAYS (WAYS), .WAY_W($clog2(WAYS)), .CTR_W(CTR_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .way_valid  (way_valid),
  .victim_way (victim_way),
  .victim_vld (victim_vld),
  .policy_b   (policy_b),
  .lead_a     (lead_a),
  .lead_b     (lead_b),
  .miss_evt   (miss_evt),
  .ctr_q      (ctr_q),
  .cur_use    (cur_use),
  .cur_ptr    (cur_ptr)
);

// File: tb/test_repl_duel_top.sv
module test_repl_duel_top;
  localparam int NSETS = 64;
  localparam int NWAYS = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       acc_valid = 1'b0;
  logic [5:0] acc_set = '0;
  logic       acc_hit = 1'b0;
  logic [1:0] acc_way = '0;
  logic [3:0] way_valid = '0;
  logic [1:0] victim_way;
  logic       victim_vld;
  logic       policy_b;
  logic       follow_b;

  always #5 clk = ~clk;

  repl_duel_top i_repl_duel_top (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_set(acc_set),
    .acc_hit(acc_hit), .acc_way(acc_way), .way_valid(way_valid),
    .victim_way(victim_way), .victim_vld(victim_vld),
    .policy_b(policy_b), .follow_b(follow_b)
  );

  typedef struct {
    int    victim;
    bit    vld;
    bit    pb;
    bit    fb;
    string req;
  } exp_t;

  exp_t  sb_q[$];
  int    checks = 0;
  int    errors = 0;
  bit    done = 0;

  bit [3:0] m_use [NSETS];
  int       m_ptr [NSETS];
  int       m_ctr = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  // scoreboard monitor: compare away from the rising edge
  always @(negedge clk) begin
    if (rst_n && acc_valid === 1'b1) begin
      if (sb_q.size() == 0) begin
        chk(1'b0, "R10", "unexpected access result", 1, 0);
      end else begin
        exp_t e;
        e = sb_q.pop_front();
        chk(victim_vld == e.vld, e.req, "victim_vld", int'(victim_vld), int'(e.vld));
        chk(policy_b == e.pb, e.req, "policy_b", int'(policy_b), int'(e.pb));
        chk(follow_b == e.fb, e.req, "follow_b", int'(follow_b), int'(e.fb));
        if (e.vld)
          chk(int'(victim_way) == e.victim, e.req, "victim_way", int'(victim_way), e.victim);
      end
    end
  end

  // driver: drives one access and predicts its outcome from the requirements
  task automatic access(input int s, input bit hit, input int hw,
                        input bit [3:0] vv, input string req);
    exp_t e;
    bit   la, lb, fb, pb;
    int   v, t;
    @(posedge clk); #1;
    acc_valid = 1'b1;
    acc_set   = 6'(s);
    acc_hit   = hit;
    acc_way   = 2'(hw);
    way_valid = vv;
    la = (s % 32) == 0;
    lb = (s % 32) == 1;
    fb = m_ctr > 0;
    pb = lb || (!la && fb);
    v = 0;
    if (vv != 4'hF) begin
      for (int i = NWAYS - 1; i >= 0; i--) if (!vv[i]) v = i;
    end else if (pb) begin
      v = m_ptr[s];
    end else begin
      for (int i = NWAYS - 1; i >= 0; i--) if (!m_use[s][i]) v = i;
    end
    e.victim = v; e.vld = !hit; e.pb = pb; e.fb = fb; e.req = req;
    sb_q.push_back(e);
    t = hit ? hw : v;
    if ((m_use[s] | (4'b1 << t)) == 4'hF) m_use[s] = 4'b1 << t;
    else                                  m_use[s] = m_use[s] | (4'b1 << t);
    if (!hit) begin
      m_ptr[s] = (v + 1) % NWAYS;
      if (la && m_ctr < 511)  m_ctr++;
      if (lb && m_ctr > -512) m_ctr--;
    end
  endtask

  task automatic idle(input int s, input bit [3:0] vv);
    @(posedge clk); #1;
    acc_valid = 1'b0;
    acc_set   = 6'(s);
    acc_hit   = 1'b0;
    way_valid = vv;
  endtask

  initial begin
    for (int s = 0; s < NSETS; s++) begin m_use[s] = '0; m_ptr[s] = 0; end
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    chk(follow_b == 1'b0, "R1", "follow_b after reset", int'(follow_b), 0);
    chk(victim_vld == 1'b0, "R10", "victim_vld while idle", int'(victim_vld), 0);

    // R6 fill of invalid ways, then R7/R8 use-bit victims on a follower set
    access(5, 0, 0, 4'b0000, "R6");
    access(5, 0, 0, 4'b0001, "R6");
    access(5, 0, 0, 4'b0101, "R6");
    access(5, 0, 0, 4'b0111, "R6");
    access(5, 0, 0, 4'b1111, "R7");
    access(5, 1, 1, 4'b1111, "R8");
    access(5, 1, 2, 4'b1111, "R8");
    access(5, 0, 0, 4'b1111, "R8");
    access(5, 0, 0, 4'b1111, "R7");
    access(5, 1, 3, 4'b1111, "R8");
    access(5, 0, 0, 4'b1111, "R7");

    // R9 rotation on a pointer sample set, hits do not move it; R2 pins it
    access(1, 0, 0, 4'b1111, "R9");
    access(1, 0, 0, 4'b1111, "R9");
    access(1, 1, 0, 4'b1111, "R9");
    access(1, 1, 3, 4'b1111, "R9");
    access(1, 0, 0, 4'b1111, "R9");
    access(1, 0, 0, 4'b1111, "R9");
    access(1, 0, 0, 4'b1111, "R9");
    access(33, 0, 0, 4'b1111, "R2");
    access(32, 0, 0, 4'b1111, "R2");

    // R3 counter steps, R5 follower choice
    access(0, 0, 0, 4'b1111, "R3");
    access(0, 0, 0, 4'b1111, "R3");
    access(0, 0, 0, 4'b1111, "R3");
    access(9, 0, 0, 4'b1111, "R5");
    access(0, 1, 2, 4'b1111, "R3");
    access(9, 0, 0, 4'b1111, "R5");
    access(1, 0, 0, 4'b1111, "R3");
    access(33, 0, 0, 4'b1111, "R3");
    access(9, 0, 0, 4'b1111, "R5");
    access(9, 1, 1, 4'b1111, "R5");

    // R10: idle cycles with miss-like inputs change nothing
    idle(1, 4'b1111);
    idle(0, 4'b1111);
    idle(5, 4'b1111);
    access(1, 0, 0, 4'b1111, "R10");
    access(5, 0, 0, 4'b1111, "R10");
    access(9, 0, 0, 4'b1111, "R10");

    // R4: drive to the upper rail and back
    for (int i = 0; i < 600; i++) access((i % 2) ? 32 : 0, 0, 0, 4'b1111, "R4");
    access(7, 0, 0, 4'b1111, "R4");
    for (int i = 0; i < 510; i++) access((i % 2) ? 33 : 1, 0, 0, 4'b1111, "R4");
    access(7, 0, 0, 4'b1111, "R4");
    access(1, 0, 0, 4'b1111, "R4");
    access(7, 0, 0, 4'b1111, "R5");
    // lower rail and back
    for (int i = 0; i < 600; i++) access(1, 0, 0, 4'b1111, "R4");
    for (int i = 0; i < 512; i++) access(0, 0, 0, 4'b1111, "R4");
    access(7, 0, 0, 4'b1111, "R5");
    access(0, 0, 0, 4'b1111, "R4");
    access(7, 0, 0, 4'b1111, "R5");

    // mixed traffic over all sets
    for (int i = 0; i < 3000; i++) begin
      int s;
      bit [3:0] vv;
      s  = $urandom_range(0, NSETS - 1);
      vv = ($urandom_range(0, 7) == 0) ? 4'($urandom_range(0, 15)) : 4'hF;
      access(s, $urandom_range(0, 2) == 0, $urandom_range(0, 3), vv,
             "R8");
    end
    idle(0, 4'h0);
    @(negedge clk);
    chk(sb_q.size() == 0, "R10", "results left in scoreboard", sb_q.size(), 0);
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL R10 watchdog: actual %0d expected %0d", 1, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule